// File: doc/BRIEF.md
# Context-cache invalidation command register

This block is the 64-bit command register through which software asks an I/O address-remapping unit to drop entries from its context cache. Software writes a requested granularity, optionally a domain identifier and a source identifier, and sets the invalidate bit in the top byte. The register holds that request, raises a request toward the context cache and waits for its acknowledgement. When the unit reports that its write buffer must be drained first, the register runs a flush handshake with the write buffer before it starts the cache request.

On completion the register clears the invalidate bit and records the granularity the cache reports it actually used. Software polls the invalidate bit to learn that the operation has finished, then reads the actual-granularity field. Only one request is in flight at a time. While one is in flight, every write to the register is dropped, so the fields that travel with the request cannot change under it.

Top module: `ctxc_inval_cmd`

## Requirements
- R1: After reset the register reads as all zeros at its address, and neither `flush_req` nor `inv_req` is asserted.
- R2: The register answers only at the aligned byte address `REG_OFFSET` (default 0x028). A read at any other address returns zero, and a write to any other address changes nothing and starts nothing.
- R3: Each write updates only the byte lanes whose enable bit is set. Lanes 0-1 hold the domain identifier (bits 15:0), lanes 2-3 hold the source identifier (bits 31:16), and lane 7 holds the requested granularity (bits 62:61). The actual-granularity field (bits 60:59) cannot be written, and every other bit reads as zero.
- R4: An invalidation starts only when a write has lane 7 enabled and bit 63 set. Bit 63 reads back as 1 from the next cycle until the operation completes. A lane-7 write with bit 63 clear does not start one, and neither does bit 63 set with lane 7 disabled.
- R5: While bit 63 reads as 1, every write is ignored: the requested granularity and both identifiers keep their values.
- R6: If `flush_cap` is 1 in the start cycle, `flush_req` rises together with bit 63 and is held until `flush_ack`. `inv_req` stays low until the cycle after `flush_ack`.
- R7: If `flush_cap` is 0 in the start cycle, `flush_req` stays low and `inv_req` rises together with bit 63.
- R8: While `inv_req` is high, `inv_gran` carries the requested granularity, with the reserved code 00 replaced by 01. The encodings are 01 for global, 10 for domain and 11 for device. `inv_dom` and `inv_src` carry the latched identifiers. All three stay stable until `inv_ack`.
- R9: After `inv_ack`, `inv_req` drops in the next cycle. One cycle later bit 63 reads 0 and bits 60:59 hold the `inv_ack_gran` value sampled with `inv_ack`.
- R10: A `flush_ack` or `inv_ack` that arrives while no operation is waiting for it has no effect on the register or on the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 8 | Byte-lane write enables |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| flush_cap | input | 1 | Capability: write-buffer flush required before completion |
| flush_req | output | 1 | Write-buffer flush request, held until acknowledged |
| flush_ack | input | 1 | Write-buffer flush acknowledge pulse |
| inv_req | output | 1 | Context-cache invalidation request, held until acknowledged |
| inv_gran | output | 2 | Granularity to perform (never 00) |
| inv_dom | output | DOM_W | Domain identifier for the request |
| inv_src | output | SRC_W | Source identifier for the request |
| inv_ack | input | 1 | Invalidation acknowledge pulse |
| inv_ack_gran | input | 2 | Granularity actually performed, valid with `inv_ack` |

## Verification
The embedded assertions check several rules on every cycle. They confirm that the fields stay frozen while an operation is in flight, that the request is ordered after the flush acknowledge or the start write, and that the request payload is stable and never carries the reserved code. They also confirm that completion follows an acknowledge by exactly one cycle and that the actual granularity is captured from the acknowledge. Other properties need stimulus and expected values and are left to the bench scenarios. These are address decode, byte-lane masking over all 256 enable patterns, reserved bits reading zero, the exact start qualifier, the reserved-to-global substitution for each requested code, and the harmlessness of stray acknowledges. The bench covers each code with and without the flush capability.

// File: rtl/ctxc_inval_pkg.sv
package ctxc_inval_pkg;

   localparam int REG_W    = 64;
   localparam int BYTE_W   = 8;
   localparam int N_LANES  = REG_W / BYTE_W;
   localparam int GRAN_W   = 2;

   // Bit positions that software and hardware both decode
   localparam int GO_POS   = 63;
   localparam int RQG_LO   = 61;
   localparam int ACG_LO   = 59;
   localparam int DOM_LO   = 0;
   localparam int SRC_LO   = 16;
   localparam int ID_LANES = 4;
   localparam int ID_W     = ID_LANES * BYTE_W;
   localparam int GO_LANE  = GO_POS / BYTE_W;

   typedef logic [GRAN_W-1:0] gran_t;

   localparam gran_t GRAN_RSVD   = 2'b00;
   localparam gran_t GRAN_GLOBAL = 2'b01;
   localparam gran_t GRAN_DOMAIN = 2'b10;
   localparam gran_t GRAN_DEVICE = 2'b11;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FLUSH = 2'd1,
      SEQ_INVAL = 2'd2,
      SEQ_DONE  = 2'd3
   } seq_state_e;

   function automatic gran_t effective_gran(input gran_t g);
      return (g == GRAN_RSVD) ? GRAN_GLOBAL : g;
   endfunction

endpackage

// File: rtl/ctxc_field_store.sv
module ctxc_field_store
   import ctxc_inval_pkg::*;
#(
   parameter int DOM_W = 16,
   parameter int SRC_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ok,
   input  logic [ID_LANES-1:0] wr_id_be,
   input  logic                wr_rq_be,
   input  logic [ID_W-1:0]     wr_id,
   input  gran_t               wr_rq,
   input  logic                done_pulse,
   input  gran_t               done_gran,
   output gran_t               req_gran,
   output gran_t               act_gran,
   output logic [DOM_W-1:0]    dom_id,
   output logic [SRC_W-1:0]    src_id
);

   localparam logic [ID_W-1:0] DOM_KEEP = ((ID_W'(1) << DOM_W) - ID_W'(1)) << DOM_LO;
   localparam logic [ID_W-1:0] SRC_KEEP = ((ID_W'(1) << SRC_W) - ID_W'(1)) << SRC_LO;
   localparam logic [ID_W-1:0] ID_KEEP  = DOM_KEEP | SRC_KEEP;

   logic [ID_W-1:0] id_q, id_d;
   gran_t           rq_q, ac_q;

   // One next-value slice per identifier byte lane
   for (genvar l = 0; l < ID_LANES; l++) begin : g_lane
      assign id_d[l*BYTE_W +: BYTE_W] =
         (wr_ok && wr_id_be[l]) ? (wr_id[l*BYTE_W +: BYTE_W] & ID_KEEP[l*BYTE_W +: BYTE_W])
                                : id_q[l*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q <= '0;
         rq_q <= GRAN_RSVD;
         ac_q <= GRAN_RSVD;
      end else begin
         id_q <= id_d;
         if (wr_ok && wr_rq_be) rq_q <= wr_rq;
         if (done_pulse)        ac_q <= done_gran;
      end
   end

   assign req_gran = rq_q;
   assign act_gran = ac_q;
   assign dom_id   = id_q[DOM_LO +: DOM_W];
   assign src_id   = id_q[SRC_LO +: SRC_W];

   // R9: the actual-granularity field takes the value reported at completion
   a_r9_act_capture: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> act_gran == $past(done_gran));

endmodule

// File: rtl/ctxc_inval_seq.sv
module ctxc_inval_seq
   import ctxc_inval_pkg::*;
#(
   parameter bit FLUSH_EN = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  flush_cap,
   input  logic  flush_ack,
   input  logic  inv_ack,
   input  gran_t inv_ack_gran,
   output logic  busy,
   output logic  flush_req,
   output logic  inv_req,
   output logic  done_pulse,
   output gran_t done_gran
);

   seq_state_e state_q;
   logic       cap_q;
   logic       cap_eff;
   gran_t      ack_gran_q;

   if (FLUSH_EN) begin : g_flush
      assign cap_eff = flush_cap;
   end else begin : g_noflush
      logic unused_cap;
      assign unused_cap = flush_cap;
      assign cap_eff    = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         cap_q      <= 1'b0;
         ack_gran_q <= GRAN_RSVD;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  cap_q   <= cap_eff;
                  state_q <= cap_eff ? SEQ_FLUSH : SEQ_INVAL;
               end
            end
            SEQ_FLUSH: begin
               if (flush_ack) state_q <= SEQ_INVAL;
            end
            SEQ_INVAL: begin
               if (inv_ack) begin
                  ack_gran_q <= inv_ack_gran;
                  state_q    <= SEQ_DONE;
               end
            end
            SEQ_DONE: state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != SEQ_IDLE);
   assign flush_req  = (state_q == SEQ_FLUSH);
   assign inv_req    = (state_q == SEQ_INVAL);
   assign done_pulse = (state_q == SEQ_DONE);
   assign done_gran  = ack_gran_q;

   // R6: with the flush capability, the cache request follows the flush acknowledge
   a_r6_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_req) && cap_q |-> $past(flush_ack));

   // R7: without the capability, the cache request follows the start write directly
   a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_req) && !cap_q |-> $past(start));

   // R9: an acknowledged request completes in the next cycle, then goes idle
   a_r9_complete: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req && inv_ack |=> done_pulse && !inv_req);
   a_r9_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !busy);

   // R10: stray acknowledges do not move an idle sequencer
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> !busy);

endmodule

// File: rtl/ctxc_inval_cmd.sv
module ctxc_inval_cmd
   import ctxc_inval_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h028,
   parameter int                DOM_W      = 16,
   parameter int                SRC_W      = 16,
   parameter bit                FLUSH_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_be,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              flush_cap,
   output logic              flush_req,
   input  logic              flush_ack,
   output logic              inv_req,
   output logic [1:0]        inv_gran,
   output logic [DOM_W-1:0]  inv_dom,
   output logic [SRC_W-1:0]  inv_src,
   input  logic              inv_ack,
   input  logic [1:0]        inv_ack_gran
);

   // Elaboration-time parameter checks
   if (ADDR_W < 4)
      $error("ADDR_W must be at least 4");
   if (REG_OFFSET[2:0] != 3'b000)
      $error("REG_OFFSET must be 8-byte aligned");
   if (DOM_W < 1 || DOM_W > SRC_LO - DOM_LO)
      $error("DOM_W must fit its two byte lanes");
   if (SRC_W < 1 || SRC_W > ID_W - SRC_LO)
      $error("SRC_W must fit its two byte lanes");
   if (RQG_LO / BYTE_W != GO_LANE || (RQG_LO + GRAN_W - 1) / BYTE_W != GO_LANE)
      $error("requested-granularity field must share the top lane with the go bit");

   logic  hit, wr_ok, start, busy, done_pulse;
   gran_t req_gran, act_gran, done_gran;
   logic [DOM_W-1:0] dom_id;
   logic [SRC_W-1:0] src_id;
   logic [REG_W-1:0] image;

   assign hit   = (reg_addr == REG_OFFSET);
   assign wr_ok = reg_wr && hit && !busy;
   assign start = wr_ok && reg_be[GO_LANE] && reg_wdata[GO_POS];

   // Write-data bits and lanes with no writable storage behind them
   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[RQG_LO-1:ID_W], reg_be[GO_LANE-1:ID_LANES]};

   ctxc_field_store #(
      .DOM_W(DOM_W),
      .SRC_W(SRC_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ok      (wr_ok),
      .wr_id_be   (reg_be[ID_LANES-1:0]),
      .wr_rq_be   (reg_be[GO_LANE]),
      .wr_id      (reg_wdata[ID_W-1:0]),
      .wr_rq      (reg_wdata[RQG_LO +: GRAN_W]),
      .done_pulse (done_pulse),
      .done_gran  (done_gran),
      .req_gran   (req_gran),
      .act_gran   (act_gran),
      .dom_id     (dom_id),
      .src_id     (src_id)
   );

   ctxc_inval_seq #(
      .FLUSH_EN(FLUSH_EN)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .flush_cap    (flush_cap),
      .flush_ack    (flush_ack),
      .inv_ack      (inv_ack),
      .inv_ack_gran (inv_ack_gran),
      .busy         (busy),
      .flush_req    (flush_req),
      .inv_req      (inv_req),
      .done_pulse   (done_pulse),
      .done_gran    (done_gran)
   );

   always_comb begin
      image                      = '0;
      image[GO_POS]              = busy;
      image[RQG_LO +: GRAN_W]    = req_gran;
      image[ACG_LO +: GRAN_W]    = act_gran;
      image[DOM_LO +: DOM_W]     = dom_id;
      image[SRC_LO +: SRC_W]     = src_id;
   end

   assign reg_rdata = hit ? image : '0;
   assign inv_gran  = effective_gran(req_gran);
   assign inv_dom   = dom_id;
   assign inv_src   = src_id;

   // R5: no field changes while an operation is in flight
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(req_gran) && $stable(dom_id) && $stable(src_id));

   // R8: the request payload is held until acknowledged
   a_r8_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req && !inv_ack |=> inv_req && $stable(inv_gran) && $stable(inv_dom) && $stable(inv_src));

   // R8: the reserved code never reaches the cache
   a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req |-> inv_gran != GRAN_RSVD);

endmodule

// File: tb/ctxc_inval_cmd_test.sv
module ctxc_inval_cmd_test;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;
   localparam logic [11:0] A_REG   = 12'h028;
   localparam logic [11:0] A_OTHER = 12'h030;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = A_REG;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_be = 8'h00;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        flush_cap = 1'b0;
   logic        flush_req;
   logic        flush_ack = 1'b0;
   logic        inv_req;
   logic [1:0]  inv_gran;
   logic [15:0] inv_dom;
   logic [15:0] inv_src;
   logic        inv_ack = 1'b0;
   logic [1:0]  inv_ack_gran = 2'b00;

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctxc_inval_cmd uut (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flush_cap(flush_cap), .flush_req(flush_req), .flush_ack(flush_ack),
      .inv_req(inv_req), .inv_gran(inv_gran), .inv_dom(inv_dom), .inv_src(inv_src),
      .inv_ack(inv_ack), .inv_ack_gran(inv_ack_gran)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] be, input logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = 8'h00;
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      summary();
   end

   logic [63:0] rv, expw, p;
   logic [31:0] sh_id;
   logic [1:0]  sh_rq, sh_ac, rq, ackg, expg;
   logic [15:0] dom, src;

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(A_REG, rv);
      chk("R1", "reset image", rv, 64'h0);
      chk("R1", "reset flush_req", {63'b0, flush_req}, 64'h0);
      chk("R1", "reset inv_req", {63'b0, inv_req}, 64'h0);

      // R3: reserved bits read zero, actual-granularity field not writable
      wr(A_REG, 8'hFF, 64'h7FFF_FFFF_FFFF_FFFF);
      rd(A_REG, rv);
      chk("R3", "reserved/act masking", rv, 64'h6000_0000_FFFF_FFFF);
      sh_id = 32'hFFFF_FFFF; sh_rq = 2'b11; sh_ac = 2'b00;

      // R2: other address neither readable nor writable
      wr(A_OTHER, 8'hFF, 64'h0000_0000_0000_0000);
      rd(A_REG, rv);
      chk("R2", "write elsewhere leaves reg", rv, 64'h6000_0000_FFFF_FFFF);
      wr(A_OTHER, 8'hFF, 64'h8000_0000_0000_0000);
      @(negedge clk);
      chk("R2", "write elsewhere no request", {62'b0, flush_req, inv_req}, 64'h0);
      rd(A_OTHER, rv);
      chk("R2", "read elsewhere", rv, 64'h0);
      rd(12'h029, rv);
      chk("R2", "misaligned read", rv, 64'h0);

      // R3: every byte-enable pattern
      for (int i = 0; i < 256; i++) begin
         p = i[0] ? 64'h2123_0000_4C3B_2A19 : 64'h7A5C_0000_B3C4_D5E6;
         wr(A_REG, i[7:0], p);
         for (int l = 0; l < 4; l++)
            if (i[l]) sh_id[l*8 +: 8] = p[l*8 +: 8];
         if (i[7]) sh_rq = p[62:61];
         rd(A_REG, rv);
         chk("R3", "byte-lane sweep", rv, {1'b0, sh_rq, sh_ac, 27'b0, sh_id});
      end

      // R4: start qualifiers
      flush_cap = 1'b0;
      wr(A_REG, 8'h7F, 64'hFFFF_FFFF_FFFF_FFFF);
      sh_id = 32'hFFFF_FFFF;
      @(negedge clk);
      rd(A_REG, rv);
      chk("R4", "go without top lane", rv, {1'b0, sh_rq, sh_ac, 27'b0, sh_id});
      chk("R4", "no request without top lane", {62'b0, flush_req, inv_req}, 64'h0);
      wr(A_REG, 8'h80, 64'h4000_0000_0000_0000);
      sh_rq = 2'b10;
      @(negedge clk);
      rd(A_REG, rv);
      chk("R4", "top lane with go clear", rv, {1'b0, sh_rq, sh_ac, 27'b0, sh_id});
      chk("R4", "no request with go clear", {62'b0, flush_req, inv_req}, 64'h0);

      // R10: stray acknowledges while idle
      @(negedge clk);
      flush_ack = 1'b1; inv_ack = 1'b1; inv_ack_gran = 2'b11;
      @(negedge clk);
      flush_ack = 1'b0; inv_ack = 1'b0;
      @(negedge clk);
      rd(A_REG, rv);
      chk("R10", "stray acks leave image", rv, {1'b0, sh_rq, sh_ac, 27'b0, sh_id});
      chk("R10", "stray acks no request", {62'b0, flush_req, inv_req}, 64'h0);

      // R4-R9: every requested code, with and without the flush capability
      for (int c = 0; c < 2; c++) begin
         for (int r = 0; r < 4; r++) begin
            rq   = r[1:0];
            ackg = 2'(r + 1 + 2 * c);
            expg = (rq == 2'b00) ? 2'b01 : rq;
            dom  = 16'h1000 + 16'(r * 16 + c);
            src  = 16'hA000 ^ 16'(r * 4 + c);
            flush_cap = c[0];
            wr(A_REG, 8'hFF, {1'b1, rq, 2'b11, 27'b0, src, dom});
            rd(A_REG, rv);
            chk("R4", "go reads back set", {63'b0, rv[63]}, 64'h1);
            chk("R6", "flush_req after start", {63'b0, flush_req}, {63'b0, c[0]});
            chk("R7", "inv_req after start", {63'b0, inv_req}, {63'b0, ~c[0]});

            // R5: write while busy is dropped
            wr(A_REG, 8'hFF, {1'b0, ~rq, 2'b00, 27'b0, ~src, ~dom});
            rd(A_REG, rv);
            chk("R5", "fields frozen while busy", {rv[62:61], rv[31:0]}, {30'b0, rq, src, dom});

            if (c == 1) begin
               chk("R6", "flush still held", {62'b0, flush_req, inv_req}, 64'h2);
               @(negedge clk);
               flush_ack = 1'b1;
               @(negedge clk);
               flush_ack = 1'b0;
               chk("R6", "cache request after flush ack", {62'b0, flush_req, inv_req}, 64'h1);
            end else begin
               chk("R7", "no flush without capability", {62'b0, flush_req, inv_req}, 64'h1);
            end

            chk("R8", "inv_gran", {62'b0, inv_gran}, {62'b0, expg});
            chk("R8", "inv_dom/inv_src", {32'b0, inv_src, inv_dom}, {32'b0, src, dom});

            @(negedge clk);
            inv_ack = 1'b1; inv_ack_gran = ackg;
            @(negedge clk);
            inv_ack = 1'b0; inv_ack_gran = 2'b00;
            rd(A_REG, rv);
            chk("R9", "request drops after ack", {63'b0, inv_req}, 64'h0);
            chk("R9", "go still set one cycle", {63'b0, rv[63]}, 64'h1);
            @(negedge clk);
            rd(A_REG, rv);
            sh_ac = ackg;
            chk("R9", "completion image", rv, {1'b0, rq, ackg, 27'b0, src, dom});
         end
      end

      summary();
   end

endmodule